// File: doc/BRIEF.md
# Active Video Boundary Detector

This block watches a digitized RGB pixel stream and locates the edges of the real picture inside the incoming raster. Each pixel is compared against a programmable minimum level. On one scan line chosen by software, the block records the first and last pixel positions that pass this test. At one pixel column chosen by software, it records the first and last line numbers that pass. Firmware then uses the four positions to centre and size the capture window.

Horizontal positions count from the leading edge of input HSYNC. Vertical positions count from the leading edge of input VSYNC. Measurements for a frame build up in working registers. All four results are copied to the output registers together on the next VSYNC leading edge, so a reader that takes the upper and lower bytes of a value in two accesses never sees results from two different frames. If a frame contains no qualifying pixel on the chosen line or at the chosen column, the start value reads as all ones and the end value reads as zero.

Top module: `active_bound_detect`

## Requirements
- R1: A pixel qualifies when at least one of its red, green or blue values is strictly greater than `data_thresh`. A component equal to the threshold does not qualify.
- R2: The pixel position is 0 in the clock where `hsync` is first sampled high after being low. It rises by one on every later clock and saturates at 2^COL_W-1.
- R3: The line number is 0 in the clock where `vsync` is first sampled high after being low. Otherwise it rises by one in each clock where an `hsync` leading edge is sampled.
- R4: `hstart_o` / `hend_o` give the position of the first / last qualifying pixel on the line whose number equals `sel_line`.
- R5: `vstart_o` / `vend_o` give the number of the first / last line whose pixel at position `sel_col` qualifies.
- R6: The four outputs change only in the clock after a `vsync` leading edge is sampled. They then show the frame that just ended, and all four change together.
- R7: After reset, and for a frame with no qualifying pixel, each start output is all ones and each end output is zero.
- R8: The pixel sampled in the same clock as a `vsync` leading edge belongs to the new frame. It is at line 0 and does not affect the results published in that clock.
- R9: Whenever a start output is not all ones, it is less than or equal to the matching end output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_r | input | PIX_W | Red component |
| pix_g | input | PIX_W | Green component |
| pix_b | input | PIX_W | Blue component |
| hsync | input | 1 | Input horizontal sync (polarity set by parameter, high by default) |
| vsync | input | 1 | Input vertical sync (polarity set by parameter, high by default) |
| data_thresh | input | PIX_W | Minimum level a component must exceed |
| sel_line | input | ROW_W | Line on which horizontal bounds are measured |
| sel_col | input | COL_W | Pixel column at which vertical bounds are measured |
| hstart_o | output | COL_W | Published horizontal active start |
| hend_o | output | COL_W | Published horizontal active end |
| vstart_o | output | ROW_W | Published vertical active start |
| vend_o | output | ROW_W | Published vertical active end |

## Verification
Two events can fall in the same clock: the frame-end publish of finished results and the first qualifying pixel of the next frame. The collision is set up by placing a bright pixel at line 0, position 0 while `sel_line` and `sel_col` are both 0, so that this pixel arrives together with the `vsync` leading edge. It is judged in two ways. The publish made in that clock must still show the previous, empty frame as all ones and zero. One frame later, all four outputs must read zero.

// File: rtl/abd_pkg.sv
package abd_pkg;

   typedef enum logic [0:0] {
      QUAL_ANY = 1'b0,
      QUAL_ALL = 1'b1
   } qual_mode_e;

   typedef enum logic [0:0] {
      SYNC_HIGH = 1'b0,
      SYNC_LOW  = 1'b1
   } sync_pol_e;

endpackage

// File: rtl/abd_sync_edge.sv
module abd_sync_edge
   import abd_pkg::*;
#(
   parameter sync_pol_e POL = SYNC_HIGH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_in,
   output logic lead_o
);

   logic norm;
   logic prev_q;

   generate
      if (POL == SYNC_HIGH) begin : g_high
         assign norm = sync_in;
      end else begin : g_low
         assign norm = ~sync_in;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= norm;
   end

   assign lead_o = norm & ~prev_q;

endmodule

// File: rtl/abd_pos_count.sv
module abd_pos_count #(
   parameter int COL_W = 12,
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             h_lead,
   input  logic             v_lead,
   output logic [COL_W-1:0] pix_o,
   output logic [ROW_W-1:0] line_o
);

   localparam logic [COL_W-1:0] PIX_MAX  = {COL_W{1'b1}};
   localparam logic [ROW_W-1:0] LINE_MAX = {ROW_W{1'b1}};

   logic [COL_W-1:0] pix_q;
   logic [ROW_W-1:0] line_q;

   always_comb begin
      if (h_lead)                pix_o = '0;
      else if (pix_q == PIX_MAX) pix_o = pix_q;
      else                       pix_o = pix_q + 1'b1;

      if (v_lead)                line_o = '0;
      else if (h_lead && line_q != LINE_MAX) line_o = line_q + 1'b1;
      else                       line_o = line_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q  <= '0;
         line_q <= '0;
      end else begin
         pix_q  <= pix_o;
         line_q <= line_o;
      end
   end

endmodule

// File: rtl/abd_qualify.sv
module abd_qualify
   import abd_pkg::*;
#(
   parameter int         PIX_W  = 8,
   parameter int         NUM_CH = 3,
   parameter qual_mode_e MODE   = QUAL_ANY
) (
   input  logic [NUM_CH*PIX_W-1:0] pix_i,
   input  logic [PIX_W-1:0]        thresh,
   output logic                    hit_o
);

   logic [NUM_CH-1:0] above;

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         assign above[c] = pix_i[c*PIX_W +: PIX_W] > thresh;
      end
      if (MODE == QUAL_ANY) begin : g_any
         assign hit_o = |above;
      end else begin : g_all
         assign hit_o = &above;
      end
   endgenerate

endmodule

// File: rtl/abd_span_track.sv
module abd_span_track #(
   parameter int POS_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_lead,
   input  logic             hit,
   input  logic [POS_W-1:0] pos,
   output logic [POS_W-1:0] first_o,
   output logic [POS_W-1:0] last_o
);

   logic             seen_q;
   logic [POS_W-1:0] first_q;
   logic [POS_W-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q  <= 1'b0;
         first_q <= '0;
         last_q  <= '0;
         first_o <= '1;
         last_o  <= '0;
      end else begin
         if (frame_lead) begin
            first_o <= seen_q ? first_q : '1;
            last_o  <= seen_q ? last_q  : '0;
         end
         if (hit) begin
            if (!seen_q || frame_lead) first_q <= pos;
            last_q <= pos;
            seen_q <= 1'b1;
         end else if (frame_lead) begin
            seen_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/active_bound_detect.sv
module active_bound_detect
   import abd_pkg::*;
#(
   parameter int         PIX_W    = 8,
   parameter int         COL_W    = 12,
   parameter int         ROW_W    = 11,
   parameter qual_mode_e QUAL     = QUAL_ANY,
   parameter sync_pol_e  SYNC_POL = SYNC_HIGH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PIX_W-1:0] pix_r,
   input  logic [PIX_W-1:0] pix_g,
   input  logic [PIX_W-1:0] pix_b,
   input  logic             hsync,
   input  logic             vsync,
   input  logic [PIX_W-1:0] data_thresh,
   input  logic [ROW_W-1:0] sel_line,
   input  logic [COL_W-1:0] sel_col,
   output logic [COL_W-1:0] hstart_o,
   output logic [COL_W-1:0] hend_o,
   output logic [ROW_W-1:0] vstart_o,
   output logic [ROW_W-1:0] vend_o
);

   localparam int NUM_CH = 3;

   generate
      if (PIX_W < 1 || PIX_W > 16) begin : g_bad_pix
         $error("PIX_W out of range");
      end
      if (COL_W < 2 || COL_W > 16) begin : g_bad_col
         $error("COL_W out of range");
      end
      if (ROW_W < 2 || ROW_W > 16) begin : g_bad_row
         $error("ROW_W out of range");
      end
   endgenerate

   logic             h_lead;
   logic             v_lead;
   logic [COL_W-1:0] cur_pix;
   logic [ROW_W-1:0] cur_line;
   logic             qual;

   abd_sync_edge #(.POL(SYNC_POL)) u_hedge (
      .clk(clk), .rst_n(rst_n), .sync_in(hsync), .lead_o(h_lead)
   );

   abd_sync_edge #(.POL(SYNC_POL)) u_vedge (
      .clk(clk), .rst_n(rst_n), .sync_in(vsync), .lead_o(v_lead)
   );

   abd_pos_count #(.COL_W(COL_W), .ROW_W(ROW_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .h_lead(h_lead), .v_lead(v_lead),
      .pix_o(cur_pix), .line_o(cur_line)
   );

   abd_qualify #(.PIX_W(PIX_W), .NUM_CH(NUM_CH), .MODE(QUAL)) u_qual (
      .pix_i({pix_b, pix_g, pix_r}), .thresh(data_thresh), .hit_o(qual)
   );

   abd_span_track #(.POS_W(COL_W)) u_htrk (
      .clk(clk), .rst_n(rst_n), .frame_lead(v_lead),
      .hit(qual && (cur_line == sel_line)), .pos(cur_pix),
      .first_o(hstart_o), .last_o(hend_o)
   );

   abd_span_track #(.POS_W(ROW_W)) u_vtrk (
      .clk(clk), .rst_n(rst_n), .frame_lead(v_lead),
      .hit(qual && (cur_pix == sel_col)), .pos(cur_line),
      .first_o(vstart_o), .last_o(vend_o)
   );

endmodule

// File: rtl/abd_chk.sv
module abd_chk
   import abd_pkg::*;
#(
   parameter int        COL_W    = 12,
   parameter int        ROW_W    = 11,
   parameter sync_pol_e SYNC_POL = SYNC_HIGH
) (
   input logic             clk,
   input logic             rst_n,
   input logic             vsync,
   input logic [COL_W-1:0] hstart_o,
   input logic [COL_W-1:0] hend_o,
   input logic [ROW_W-1:0] vstart_o,
   input logic [ROW_W-1:0] vend_o
);

   logic vs_act;
   assign vs_act = (SYNC_POL == SYNC_HIGH) ? vsync : ~vsync;

   // R6
   publish_only_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(vs_act) |=> ($stable(hstart_o) && $stable(hend_o) &&
                          $stable(vstart_o) && $stable(vend_o)));

   // R9
   h_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hstart_o != '1) |-> (hstart_o <= hend_o));

   // R9
   v_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vstart_o != '1) |-> (vstart_o <= vend_o));

   // R7
   h_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hstart_o == '1) |-> (hend_o == '0 || hend_o == '1));

   // R7
   v_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vstart_o == '1) |-> (vend_o == '0 || vend_o == '1));

endmodule

bind active_bound_detect abd_chk #(
   .COL_W(COL_W), .ROW_W(ROW_W), .SYNC_POL(SYNC_POL)
) u_abd_chk (
   .clk(clk), .rst_n(rst_n), .vsync(vsync),
   .hstart_o(hstart_o), .hend_o(hend_o),
   .vstart_o(vstart_o), .vend_o(vend_o)
);

// File: tb/active_bound_detect_test.sv
module active_bound_detect_test;

   localparam int COL_W = 12;
   localparam int ROW_W = 11;
   localparam int MAXP  = (1 << COL_W) - 1;
   localparam int MAXL  = (1 << ROW_W) - 1;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n;
   logic [7:0]       pr, pg, pb, th;
   logic             hs, vs;
   logic [ROW_W-1:0] sl;
   logic [COL_W-1:0] sc;
   logic [COL_W-1:0] hst, hen;
   logic [ROW_W-1:0] vst, ven;

   active_bound_detect uut (
      .clk(clk), .rst_n(rst_n), .pix_r(pr), .pix_g(pg), .pix_b(pb),
      .hsync(hs), .vsync(vs), .data_thresh(th), .sel_line(sl), .sel_col(sc),
      .hstart_o(hst), .hend_o(hen), .vstart_o(vst), .vend_o(ven)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   string req   = "R7";
   int    pat   = 0;

   // behavioural reference state
   int m_phs, m_pvs, m_pix, m_line;
   int m_hseen, m_hf, m_hl, m_vseen, m_vf, m_vl;
   int e_hs, e_he, e_vs, e_ve;

   task automatic cmp(string tag, string what, int act, int exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phs = 0; m_pvs = 0; m_pix = 0; m_line = 0;
         m_hseen = 0; m_hf = 0; m_hl = 0; m_vseen = 0; m_vf = 0; m_vl = 0;
         e_hs = MAXP; e_he = 0; e_vs = MAXL; e_ve = 0;
      end else begin
         int hr, vr, cp, cl, q;
         hr = (hs && !m_phs) ? 1 : 0;
         vr = (vs && !m_pvs) ? 1 : 0;
         cp = hr ? 0 : ((m_pix < MAXP) ? m_pix + 1 : MAXP);
         cl = vr ? 0 : (hr ? ((m_line < MAXL) ? m_line + 1 : MAXL) : m_line);
         q  = (pr > th || pg > th || pb > th) ? 1 : 0;
         if (vr) begin
            e_hs = m_hseen ? m_hf : MAXP;
            e_he = m_hseen ? m_hl : 0;
            e_vs = m_vseen ? m_vf : MAXL;
            e_ve = m_vseen ? m_vl : 0;
            m_hseen = 0;
            m_vseen = 0;
         end
         if (q && cl == int'(sl)) begin
            if (!m_hseen) m_hf = cp;
            m_hl = cp; m_hseen = 1;
         end
         if (q && cp == int'(sc)) begin
            if (!m_vseen) m_vf = cl;
            m_vl = cl; m_vseen = 1;
         end
         m_pix = cp; m_line = cl; m_phs = hs; m_pvs = vs;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         cmp(req, "hstart", int'(hst), e_hs);
         cmp(req, "hend",   int'(hen), e_he);
         cmp(req, "vstart", int'(vst), e_vs);
         cmp(req, "vend",   int'(ven), e_ve);
      end
   end

   function automatic logic [23:0] pixval(int l, int p);
      logic [7:0] r, g, b;
      r = 0; g = 0; b = 0;
      case (pat)
         1: if (l >= 3 && l <= 8 && p >= 10 && p <= 30) r = 8'h80;
         2: if (l >= 3 && l <= 8 && p >= 10 && p <= 30) r = 8'h40;
         3: begin
            if (l == 5 && (p == 12 || p == 33)) b = 8'h41;
            if ((l == 2 || l == 9) && p == 15) g = 8'h41;
         end
         4: if (l == 0 && p == 0) r = 8'hff;
         5: if (l == 1 && (p == 20 || p >= 4090)) r = 8'hff;
         default: ;
      endcase
      return {r, g, b};
   endfunction

   int    w_on = 0;
   int    w_hs, w_he, w_vs, w_ve;
   string w_tag;

   task automatic want(string tag, int a, int b, int c, int d);
      w_on = 1; w_tag = tag; w_hs = a; w_he = b; w_vs = c; w_ve = d;
   endtask

   task automatic frame(int lines, int ht);
      for (int l = 0; l < lines; l++) begin
         for (int p = 0; p < ht; p++) begin
            @(negedge clk);
            if (l == 0 && p == 1 && w_on) begin
               cmp(w_tag, "hstart", int'(hst), w_hs);
               cmp(w_tag, "hend",   int'(hen), w_he);
               cmp(w_tag, "vstart", int'(vst), w_vs);
               cmp(w_tag, "vend",   int'(ven), w_ve);
               w_on = 0;
            end
            hs = (p < 4);
            vs = (l < 2);
            {pr, pg, pb} = pixval(l, p);
         end
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; hs = 0; vs = 0; pr = 0; pg = 0; pb = 0;
      th = 8'h40; sl = 5; sc = 15;
      repeat (3) @(negedge clk);
      // R7: reset values
      cmp("R7", "reset hstart", int'(hst), MAXP);
      cmp("R7", "reset hend",   int'(hen), 0);
      cmp("R7", "reset vstart", int'(vst), MAXL);
      cmp("R7", "reset vend",   int'(ven), 0);
      rst_n = 1'b1;

      req = "R7"; pat = 0; frame(12, 40);
      // R4 R5 R3: solid box
      req = "R4"; pat = 1; frame(12, 40);
      want("R4", 10, 30, 3, 8);
      // R1 any channel, sparse dots give first and last
      req = "R5"; pat = 3; frame(12, 40);
      want("R5", 12, 33, 2, 9);
      // R1: component equal to threshold does not qualify
      req = "R1"; pat = 2; frame(12, 40);
      want("R1", MAXP, 0, MAXL, 0);
      // R8: hit in the vsync lead cycle goes to the new frame
      req = "R8"; pat = 4; sl = 0; sc = 0; frame(12, 40);
      want("R8", 0, 0, 0, 0);
      req = "R6"; pat = 0; frame(12, 40);
      want("R6", MAXP, 0, MAXL, 0);
      // R2: pixel position saturates on an over-long line
      req = "R2"; pat = 5; sl = 1; sc = 20; frame(3, 4200);
      want("R2", 20, MAXP, 1, 1);
      req = "R3"; pat = 0; frame(4, 40);
      summary();
      $finish;
   end

endmodule